// File: doc/BRIEF.md
# Bus-Master DMA Channel with Command and Status Registers

This block is a single bus-master DMA channel meant to sit next to a SCSI protocol core. Software programs it through a small register window: a remaining byte count, a memory address, a command byte that picks the operation and the direction, and a status byte. Once started, the channel moves data between an internal byte FIFO and a memory port. The memory port uses a request/acknowledge handshake. The device side of the FIFO is a plain byte push/pop port that the protocol core uses.

The channel has four states. `ST_IDLE` waits for a command. `ST_RUN` decides the next beat or ends the transfer. `ST_BEAT` holds one memory request until it is acknowledged. `ST_BLAST` flushes the leftover FIFO bytes to memory.

The transitions are:
- idle→run on a start command;
- idle→blast on a blast command when the FIFO is not empty;
- run→beat when the FIFO can supply or accept the next beat;
- run→idle on an abort or when the count is zero;
- beat→run on a clean acknowledge;
- beat→idle on an error response or on an abort pending at the acknowledge;
- blast→idle on the acknowledge.

A blast with an empty FIFO stays in idle and reports completion at once, so software that waits for blast completion is never left waiting. The interrupt output is the OR of the error, abort, done and forwarded core-interrupt status bits.

Top module: `dma_bm_engine`

## Requirements
- R1: After reset the command, count, address and status registers read 0, `irq` is low, `mem_req` is low and the FIFO is empty.
- R2: The register index is `reg_addr[7:2]`. Index 0x10 is the command byte, 0x11 the 32-bit count, 0x12 the 32-bit address and 0x15 the status byte. The command reads back the last byte written to it.
- R3: Command bits [1:0] select the operation: 0 idle, 1 blast, 2 abort, 3 start. On start, bit 7 = 1 moves FIFO bytes into memory with writes, and bit 7 = 0 reads memory into the FIFO. Start and blast are ignored while the channel is busy.
- R4: Each beat moves n = min(count, 4) bytes on byte lanes 0..n-1 of `mem_be`. After an acknowledged beat, the count drops by n and the address rises by n. A beat is not requested until the FIFO holds n bytes (write direction) or has n free entries (read direction).
- R5: When a started transfer reaches a count of zero, status bit 3 (done) sets and the channel returns to idle. A start with a count of zero reports done without any memory request.
- R6: An abort command during an active transfer ends it after any outstanding beat completes and sets status bit 2. The remaining count is kept.
- R7: An error response (`mem_err` with `mem_ack`) sets status bit 1 and returns the channel to idle. That beat changes neither the count, the address nor the FIFO.
- R8: Blast writes min(FIFO level, 4) residual bytes at the current address, with lanes 0..n-1 enabled, removes them from the FIFO and then sets status bit 5. With an empty FIFO, bit 5 sets with no memory request.
- R9: Reading the status register clears bits 1, 2 and 3 after returning them. Writing the idle operation clears bits 1, 2, 3 and 5.
- R10: Status bit 4 mirrors the `core_irq` input. Status bit 0 reads 0.
- R11: `irq` is high exactly when status bit 1, 2, 3 or 4 is set. Bit 5 does not raise it.
- R12: Writes to the count and address registers are ignored while the channel is busy.
- R13: Once raised, `mem_req` stays high with stable `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes read-to-clear) |
| reg_addr | input | 8 | Register byte offset (index times four) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| core_irq | input | 1 | Interrupt from the protocol core, forwarded to status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, lane 0 is the oldest FIFO byte |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| dev_push | input | 1 | Device pushes one byte into the FIFO |
| dev_push_data | input | 8 | Byte pushed by the device |
| dev_pop | input | 1 | Device pops one byte from the FIFO |
| dev_pop_data | output | 8 | Byte at the FIFO head |
| fifo_level | output | 4 | Number of bytes in the FIFO |

## Verification
A register write takes effect at the clock edge that samples it. The first `mem_req` of a transfer appears two edges after the start write: one edge to enter run and one to enter beat. A status bit and `irq` change one edge after the cycle in which the state machine reaches its decision. The count, address and FIFO level change on the acknowledge edge. The bench drives every input at the falling edge and samples combinational read data 1 ns later. It waits for `irq` before reading results, or lets a fixed number of cycles pass for blast completion, so every check lands after all of these edges.

// File: rtl/dma_bm_pkg.sv
package dma_bm_pkg;

    localparam logic [5:0] IDX_CMD  = 6'h10;
    localparam logic [5:0] IDX_CNT  = 6'h11;
    localparam logic [5:0] IDX_ADDR = 6'h12;
    localparam logic [5:0] IDX_STAT = 6'h15;

    localparam logic [1:0] OP_IDLE  = 2'd0;
    localparam logic [1:0] OP_BLAST = 2'd1;
    localparam logic [1:0] OP_ABORT = 2'd2;
    localparam logic [1:0] OP_START = 2'd3;

    localparam int CMD_DIR_BIT = 7;

    localparam int SB_ERR   = 1;
    localparam int SB_ABORT = 2;
    localparam int SB_DONE  = 3;
    localparam int SB_CORE  = 4;
    localparam int SB_BLAST = 5;

    localparam int BEAT_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_BEAT,
        ST_BLAST
    } eng_state_t;

    function automatic logic [3:0] lane_mask(input logic [2:0] n);
        logic [4:0] m;
        m = (5'd1 << n) - 5'd1;
        return m[3:0];
    endfunction

endpackage

// File: rtl/dma_byte_fifo.sv
module dma_byte_fifo #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_push,
    input  logic [7:0]    d_push_data,
    input  logic          d_pop,
    output logic [7:0]    d_pop_data,
    input  logic [2:0]    e_push_n,
    input  logic [31:0]   e_push_word,
    input  logic [2:0]    e_pop_n,
    output logic [31:0]   peek_word,
    output logic [LW-1:0] level
);

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_acc, pop_acc;
    logic [2:0]    n_push, n_pop;

    assign push_acc   = d_push && (e_push_n == 3'd0) && (level < LW'(DEPTH));
    assign pop_acc    = d_pop && (e_pop_n == 3'd0) && (level != '0);
    assign n_push     = (e_push_n != 3'd0) ? e_push_n : {2'b00, push_acc};
    assign n_pop      = (e_pop_n != 3'd0) ? e_pop_n : {2'b00, pop_acc};
    assign d_pop_data = mem_q[rd_ptr];

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            peek_word[8*k +: 8] = mem_q[rd_ptr + AW'(k)];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (3'(k) < n_push) begin
                    mem_q[wr_ptr + AW'(k)] <= (e_push_n != 3'd0) ? e_push_word[8*k +: 8]
                                                                 : d_push_data;
                end
            end
            wr_ptr <= wr_ptr + AW'(n_push);
            rd_ptr <= rd_ptr + AW'(n_pop);
            level  <= level + LW'(n_push) - LW'(n_pop);
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        LW'(e_pop_n) <= level);
    a_r4_engine_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (e_push_n != 3'd0) |-> (LW'(e_push_n) <= LW'(DEPTH) - level));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_bm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_start,
    input  logic          go_blast,
    input  logic          go_abort,
    input  logic          dir_in,
    input  logic          ld_cnt,
    input  logic          ld_addr,
    input  logic [31:0]   ld_data,
    output logic [31:0]   cnt_o,
    output logic [31:0]   addr_o,
    output logic          busy_o,
    output logic          ev_done,
    output logic          ev_err,
    output logic          ev_abort,
    output logic          ev_blast,
    input  logic [LW-1:0] level,
    input  logic [31:0]   peek_word,
    output logic [2:0]    pop_n,
    output logic [2:0]    push_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err
);

    eng_state_t state, nxt;
    logic [31:0] cnt, addr;
    logic        dir_q, abort_pend;
    logic [2:0]  beat_n, bl_n, bl_lvl;
    logic        rdy, stop_req;

    assign beat_n   = (cnt >= 32'(BEAT_BYTES)) ? 3'd4 : {1'b0, cnt[1:0]};
    assign bl_lvl   = (level >= LW'(BEAT_BYTES)) ? 3'd4 : 3'(level);
    assign rdy      = dir_q ? (level >= LW'(beat_n))
                            : ((LW'(DEPTH) - level) >= LW'(beat_n));
    assign stop_req = abort_pend || go_abort;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        ev_done  = 1'b0;
        ev_err   = 1'b0;
        ev_abort = 1'b0;
        ev_blast = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_be   = 4'h0;
        pop_n    = 3'd0;
        push_n   = 3'd0;
        unique case (state)
            ST_IDLE: begin
                if (go_start) begin
                    nxt = ST_RUN;
                end else if (go_blast) begin
                    if (level == '0) ev_blast = 1'b1;
                    else             nxt = ST_BLAST;
                end
            end
            ST_RUN: begin
                if (stop_req) begin
                    ev_abort = 1'b1;
                    nxt      = ST_IDLE;
                end else if (cnt == 32'd0) begin
                    ev_done = 1'b1;
                    nxt     = ST_IDLE;
                end else if (rdy) begin
                    nxt = ST_BEAT;
                end
            end
            ST_BEAT: begin
                mem_req = 1'b1;
                mem_we  = dir_q;
                mem_be  = lane_mask(beat_n);
                if (mem_ack) begin
                    if (mem_err) begin
                        ev_err = 1'b1;
                        nxt    = ST_IDLE;
                    end else begin
                        if (dir_q) pop_n  = beat_n;
                        else       push_n = beat_n;
                        if (stop_req) begin
                            ev_abort = 1'b1;
                            nxt      = ST_IDLE;
                        end else begin
                            nxt = ST_RUN;
                        end
                    end
                end
            end
            ST_BLAST: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                mem_be  = lane_mask(bl_n);
                if (mem_ack) begin
                    ev_blast = 1'b1;
                    if (mem_err) ev_err = 1'b1;
                    else         pop_n  = bl_n;
                    nxt = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            addr       <= '0;
            dir_q      <= 1'b0;
            abort_pend <= 1'b0;
            bl_n       <= 3'd0;
        end else begin
            if (state == ST_IDLE) begin
                if (ld_cnt)   cnt   <= ld_data;
                if (ld_addr)  addr  <= ld_data;
                if (go_start) dir_q <= dir_in;
                if (go_blast) bl_n  <= bl_lvl;
            end
            if (state == ST_BEAT && mem_ack && !mem_err) begin
                cnt  <= cnt - 32'(beat_n);
                addr <= addr + 32'(beat_n);
            end
            if (state == ST_BLAST && mem_ack && !mem_err) begin
                addr <= addr + 32'(bl_n);
            end
            if (nxt == ST_IDLE) abort_pend <= 1'b0;
            else if (state == ST_BEAT && go_abort) abort_pend <= 1'b1;
        end
    end

    assign cnt_o     = cnt;
    assign addr_o    = addr;
    assign busy_o    = (state != ST_IDLE);
    assign mem_addr  = addr;
    assign mem_wdata = peek_word;

    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata)));
    a_r12_cnt_no_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (cnt <= $past(cnt)));
    a_r4_lanes_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));
    a_r5_done_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> (cnt_o == 32'd0));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_bm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy,
    input  logic [31:0] cnt,
    input  logic [31:0] addr,
    input  logic        ev_done,
    input  logic        ev_err,
    input  logic        ev_abort,
    input  logic        ev_blast,
    input  logic        core_irq,
    output logic        go_start,
    output logic        go_blast,
    output logic        go_abort,
    output logic        dir,
    output logic        ld_cnt,
    output logic        ld_addr,
    output logic        irq
);

    logic [7:0] cmd_q;
    logic       st_err, st_abort, st_done, st_blast;
    logic       wr_cmd, idle_wr, rd_stat, clr_sticky;
    logic [1:0] op;

    assign op         = reg_wdata[1:0];
    assign wr_cmd     = reg_wr && (reg_idx == IDX_CMD);
    assign idle_wr    = wr_cmd && (op == OP_IDLE);
    assign rd_stat    = reg_rd && (reg_idx == IDX_STAT);
    assign clr_sticky = rd_stat || idle_wr;
    assign go_start   = wr_cmd && (op == OP_START) && !busy;
    assign go_blast   = wr_cmd && (op == OP_BLAST) && !busy;
    assign go_abort   = wr_cmd && (op == OP_ABORT);
    assign dir        = reg_wdata[CMD_DIR_BIT];
    assign ld_cnt     = reg_wr && (reg_idx == IDX_CNT) && !busy;
    assign ld_addr    = reg_wr && (reg_idx == IDX_ADDR) && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            st_err   <= 1'b0;
            st_abort <= 1'b0;
            st_done  <= 1'b0;
            st_blast <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= reg_wdata[7:0];
            st_err   <= ev_err   || (st_err   && !clr_sticky);
            st_abort <= ev_abort || (st_abort && !clr_sticky);
            st_done  <= ev_done  || (st_done  && !clr_sticky);
            st_blast <= ev_blast || (st_blast && !(idle_wr || go_start || go_blast));
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            IDX_CMD:  reg_rdata = {24'h0, cmd_q};
            IDX_CNT:  reg_rdata = cnt;
            IDX_ADDR: reg_rdata = addr;
            IDX_STAT: begin
                reg_rdata[SB_ERR]   = st_err;
                reg_rdata[SB_ABORT] = st_abort;
                reg_rdata[SB_DONE]  = st_done;
                reg_rdata[SB_CORE]  = core_irq;
                reg_rdata[SB_BLAST] = st_blast;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = st_err || st_abort || st_done || core_irq;

    a_r9_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !ev_done) |=> !st_done);
    a_r11_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> irq);
    a_r9_idle_clears_blast: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wr && !ev_blast) |=> !st_blast);

endmodule

// File: rtl/dma_bm_engine.sv
module dma_bm_engine #(
    parameter int FIFO_DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [7:0]                       reg_addr,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    output logic                             irq,
    input  logic                             core_irq,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [31:0]                      mem_addr,
    output logic [3:0]                       mem_be,
    output logic [31:0]                      mem_wdata,
    input  logic [31:0]                      mem_rdata,
    input  logic                             mem_ack,
    input  logic                             mem_err,
    input  logic                             dev_push,
    input  logic [7:0]                       dev_push_data,
    input  logic                             dev_pop,
    output logic [7:0]                       dev_pop_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level
);

    localparam int LW = $clog2(FIFO_DEPTH + 1);

    logic        go_start, go_blast, go_abort, dir, ld_cnt, ld_addr, busy;
    logic        ev_done, ev_err, ev_abort, ev_blast;
    logic [31:0] cnt, addr, peek_word;
    logic [2:0]  pop_n, push_n;
    logic [LW-1:0] level;

    dma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_addr[7:2]),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .cnt(cnt), .addr(addr),
        .ev_done(ev_done), .ev_err(ev_err), .ev_abort(ev_abort), .ev_blast(ev_blast),
        .core_irq(core_irq),
        .go_start(go_start), .go_blast(go_blast), .go_abort(go_abort),
        .dir(dir), .ld_cnt(ld_cnt), .ld_addr(ld_addr), .irq(irq)
    );

    dma_engine #(.DEPTH(FIFO_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go_start(go_start), .go_blast(go_blast), .go_abort(go_abort),
        .dir_in(dir), .ld_cnt(ld_cnt), .ld_addr(ld_addr), .ld_data(reg_wdata),
        .cnt_o(cnt), .addr_o(addr), .busy_o(busy),
        .ev_done(ev_done), .ev_err(ev_err), .ev_abort(ev_abort), .ev_blast(ev_blast),
        .level(level), .peek_word(peek_word), .pop_n(pop_n), .push_n(push_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err)
    );

    dma_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .d_push(dev_push), .d_push_data(dev_push_data),
        .d_pop(dev_pop), .d_pop_data(dev_pop_data),
        .e_push_n(push_n), .e_push_word(mem_rdata),
        .e_pop_n(pop_n), .peek_word(peek_word), .level(level)
    );

    assign fifo_level = level;

endmodule

// File: tb/sim_dma_bm_engine.sv
module sim_dma_bm_engine;

    localparam logic [5:0] I_CMD = 6'h10, I_CNT = 6'h11, I_ADR = 6'h12, I_STA = 6'h15;
    // {dir[23:16], count[15:8], addr[7:0]}
    localparam logic [23:0] VEC [6] = '{24'h01_08_00, 24'h01_05_20, 24'h00_08_40,
                                        24'h00_03_60, 24'h01_00_80, 24'h00_06_84};

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0, core_irq = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 0;
    logic irq, mem_req, mem_we, mem_ack = 0, mem_err = 0;
    logic [3:0] mem_be, fifo_level;
    logic dev_push = 0, dev_pop = 0;
    logic [7:0] dev_push_data = 0, dev_pop_data;
    logic [7:0] mbytes [256];
    logic err_inj = 0;
    int beats = 0, n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    dma_bm_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .core_irq(core_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .dev_push(dev_push), .dev_push_data(dev_push_data), .dev_pop(dev_pop),
        .dev_pop_data(dev_pop_data), .fifo_level(fifo_level)
    );

    // memory responder: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 0;
            mem_err <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            mem_err <= mem_req && !mem_ack && err_inj;
            if (mem_req && !mem_ack) begin
                beats <= beats + 1;
                for (int k = 0; k < 4; k++) begin
                    mem_rdata[8*k +: 8] <= mbytes[mem_addr[7:0] + 8'(k)];
                    if (mem_we && mem_be[k] && !err_inj)
                        mbytes[mem_addr[7:0] + 8'(k)] <= mem_wdata[8*k +: 8];
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = {idx, 2'b00}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = {idx, 2'b00};
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        dev_push = 1; dev_push_data = b;
        @(negedge clk);
        dev_push = 0;
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk);
        dev_pop = 1;
        #1 b = dev_pop_data;
        @(negedge clk);
        dev_pop = 0;
    endtask

    task automatic wait_irq(input string tag);
        for (int t = 0; t < 400; t++) begin
            if (irq) break;
            @(negedge clk);
        end
        check(tag, 32'(irq), 32'd1);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0] b;
        for (int a = 0; a < 256; a++) mbytes[a] = 8'(a) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1;
        check("R1 irq", 32'(irq), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 level", 32'(fifo_level), 0);
        rd(I_CMD, d); check("R1 cmd", d, 0);
        rd(I_CNT, d); check("R1 cnt", d, 0);
        rd(I_ADR, d); check("R1 addr", d, 0);
        rd(I_STA, d); check("R1 status", d, 0);

        // table of transfers: R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            logic dir;
            logic [7:0] cnt, adr;
            int b0;
            dir = VEC[v][16]; cnt = VEC[v][15:8]; adr = VEC[v][7:0];
            wr(I_CNT, 32'(cnt));
            wr(I_ADR, 32'(adr));
            if (dir) for (int i = 0; i < int'(cnt); i++) push(8'hA0 + 8'(v * 16 + i));
            b0 = beats;
            wr(I_CMD, {24'h0, dir, 5'b0, 2'b11});
            wait_irq("R5 done irq");
            rd(I_STA, d); check("R5 done status", d, 32'h08);
            #1 check("R11 irq low after read", 32'(irq), 0);
            rd(I_CNT, d); check("R4 count zero", d, 0);
            rd(I_ADR, d); check("R4 addr advance", d, 32'(adr) + 32'(cnt));
            check("R4 beat count", 32'(beats - b0), (32'(cnt) + 3) / 4);
            if (dir) begin
                for (int i = 0; i < int'(cnt); i++)
                    check("R3 write data", 32'(mbytes[adr + 8'(i)]), 32'(8'hA0 + 8'(v * 16 + i)));
                check("R4 lane untouched", 32'(mbytes[adr + cnt]), 32'((adr + cnt) ^ 8'h5A));
            end else begin
                check("R3 read level", 32'(fifo_level), 32'(cnt));
                for (int i = 0; i < int'(cnt); i++) begin
                    pop(b);
                    check("R3 read data", 32'(b), 32'((adr + 8'(i)) ^ 8'h5A));
                end
            end
            wr(I_CMD, 0);
        end

        // R10 R11 core interrupt
        @(negedge clk); core_irq = 1;
        rd(I_STA, d); check("R10 core bit", d, 32'h10);
        check("R11 irq core", 32'(irq), 1);
        @(negedge clk); core_irq = 0;

        // R6 R12 abort of a stalled transfer, ignored writes
        wr(I_CNT, 8); wr(I_ADR, 32'hA0);
        wr(I_CMD, 32'h83);
        repeat (5) @(negedge clk);
        check("R4 stalled no req", 32'(mem_req), 0);
        wr(I_CNT, 32'h99);
        wr(I_ADR, 32'h77);
        wr(I_CMD, 32'h02);
        wait_irq("R6 abort irq");
        wr(I_CMD, 32'h00);
        rd(I_STA, d); check("R9 idle clears", d, 0);
        wr(I_CMD, 32'h83);
        wr(I_CMD, 32'h02);
        wait_irq("R6 abort irq 2");
        rd(I_STA, d); check("R6 abort status", d, 32'h04);
        rd(I_STA, d); check("R9 read clears", d, 0);
        rd(I_CNT, d); check("R12 count kept", d, 8);
        rd(I_ADR, d); check("R12 addr kept", d, 32'hA0);

        // R7 error response
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        wr(I_CNT, 4); wr(I_ADR, 32'hB0);
        err_inj = 1;
        wr(I_CMD, 32'h83);
        wait_irq("R7 err irq");
        err_inj = 0;
        rd(I_STA, d); check("R7 error status", d, 32'h02);
        rd(I_CNT, d); check("R7 count unchanged", d, 4);
        rd(I_ADR, d); check("R7 addr unchanged", d, 32'hB0);
        check("R7 fifo unchanged", 32'(fifo_level), 4);

        // R8 blast of three residual bytes
        pop(b);
        wr(I_ADR, 32'hC0);
        wr(I_CMD, 32'h81);
        repeat (8) @(negedge clk);
        rd(I_STA, d); check("R8 blast status", d, 32'h20);
        check("R11 blast no irq", 32'(irq), 0);
        check("R8 fifo emptied", 32'(fifo_level), 0);
        check("R8 byte0", 32'(mbytes[8'hC0]), 32'h22);
        check("R8 byte1", 32'(mbytes[8'hC1]), 32'h33);
        check("R8 byte2", 32'(mbytes[8'hC2]), 32'h44);
        check("R8 lane3 untouched", 32'(mbytes[8'hC3]), 32'(8'hC3 ^ 8'h5A));
        rd(I_ADR, d); check("R8 addr advance", d, 32'hC3);

        // R8 R9 blast with empty FIFO
        wr(I_CMD, 32'h00);
        rd(I_STA, d); check("R9 idle clears blast", d, 0);
        begin
            int b0;
            b0 = beats;
            wr(I_CMD, 32'h01);
            rd(I_STA, d); check("R8 empty blast status", d, 32'h20);
            check("R8 empty blast no beat", 32'(beats - b0), 0);
        end

        // R2 command readback
        wr(I_CMD, 32'h74);
        rd(I_CMD, d); check("R2 cmd readback", d, 32'h74);

        finish_run();
    end

endmodule